// File: doc/BRIEF.md
# Dual-Group Frequency Window Checker

This block decides whether a test clock (a recovered or oscillator-derived clock that has already been divided down) runs close to one of two programmed frequencies. It counts rising edges of the test clock over a measurement window of a fixed number of rising edges of a 25 MHz reference clock. It then compares the count with two expected values, called group 0 and group 1. Each group has its own arm bit and its own 4-bit tolerance. Two groups let a single setting accept either of two harmonically related rates. Loading the same value into both groups gives a plain single-window check.

The expected count for a full-rate clock is the rate in Gbps multiplied by 1280, because the default window lasts 1.28 us. For example, 10 Gbps gives 12800 and 8.5 Gbps gives 10880. When the clock is divided before it reaches this block, software scales the expected value by the same ratio.

The test-clock count crosses into the system clock domain as a Gray code through a two-flop synchronizer. The reference clock is sampled as a level in the system domain. A byte-wide register write port holds the configuration. The check is restarted by raising and then lowering a soft reset input. Status updates once at the end of each window and stays unchanged in between.

Top module: `freq_window_chk`

## Requirements
- R1: After `rst`, `freq_ok`, `grp_match` and `grp_hit` are 0. All configuration fields reset to 0, so both groups are unarmed and the reference is disabled.
- R2: The write map places each group g at two addresses. Address 2g holds the expected count bits 7:0. Address 2g+1 bits 6:0 hold expected count bits 14:8, and its bit 7 is the group's arm bit. Address 4 holds the tolerance nibble of group 0 in bits 3:0 and of group 1 in bits 7:4. Address 5 bit 0 is the reference enable.
- R3: The measured count is the number of test-clock rising edges between two sampling points that are WIN_LEN (default 32) reference rising edges apart. `grp_match[g]` is 1 when group g is armed and |measured - expected| <= tolerance << TOL_SHIFT (default shift 0). The boundary is inclusive.
- R4: A group whose arm bit is 0 never reports a match, even when its expected count equals the measured count.
- R5: `freq_ok` equals the OR of the two group matches. `grp_hit` is 1 only when group 1 matches and group 0 does not; otherwise it is 0.
- R6: The status outputs change only at the end of a window. A configuration change in the middle of a window leaves the status unchanged until the next window ends.
- R7: While `chk_rst` is 1, all status outputs are 0 and no window runs. After it returns to 0, the first reference edge starts a new window, so the first evaluation comes no sooner than WIN_LEN reference periods later.
- R8: While the reference enable is 0, all status outputs are 0 and no evaluation takes place. Setting the enable starts a window in the same way as releasing `chk_rst`.
- R9: The test-clock counter changes by one Gray step per test-clock edge, so counts are exact for any test clock slower than `clk`.
- R10: A tolerance of 0 accepts only an exact count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the registers, the window logic and the status |
| rst | input | 1 | Synchronous active-high reset |
| tst_clk | input | 1 | Divided test clock being measured |
| ref_clk | input | 1 | 25 MHz reference clock that times the window |
| chk_rst | input | 1 | Soft reset of the check; raise, then lower, to restart |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| grp_match | output | 2 | Per-group match from the last completed window |
| grp_hit | output | 1 | Matching group: 1 only when group 1 alone matches |
| freq_ok | output | 1 | At least one armed group matched in the last window |

## Verification
A wrong window counter or a stale start snapshot shows up as a measured count that is too high or too low. That error turns an exact or edge-of-tolerance case into the opposite verdict on `grp_match` at the first window end, about 1.34 us after a restart. A lost clear on the soft reset or on the reference enable leaves `freq_ok` high during a hold, which can be seen within a few cycles. A status register that reloads outside the window end shows up as a `freq_ok` change right after a configuration write in the middle of a window. Tolerance, field-position and arm-bit faults flip the verdict of a boundary case that sits exactly one count inside or outside the limit.

// File: rtl/fwc_pkg.sv
`timescale 1ns/1ps
package fwc_pkg;
  localparam int NGRP  = 2;
  localparam int EXP_W = 15;
  localparam int TOL_W = 4;
  localparam int SEL_W = (NGRP > 1) ? $clog2(NGRP) : 1;

  localparam logic [2:0] A_TOL = 3'd4;
  localparam logic [2:0] A_CTL = 3'd5;

  typedef struct packed {
    logic             arm;
    logic [EXP_W-1:0] cnt;
    logic [TOL_W-1:0] tol;
  } grp_cfg_t;
endpackage

// File: rtl/fwc_regs.sv
`timescale 1ns/1ps
module fwc_regs
  import fwc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [2:0]                wr_addr,
  input  logic [7:0]                wr_data,
  output grp_cfg_t [NGRP-1:0]       cfg,
  output logic                      ref_en
);
  logic [7:0] lo_q [NGRP];
  logic [7:0] hi_q [NGRP];
  logic [7:0] tol_q;
  logic       ref_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NGRP; g++) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end
      tol_q    <= '0;
      ref_en_q <= 1'b0;
    end else if (wr_en) begin
      for (int g = 0; g < NGRP; g++) begin
        if (wr_addr == 3'(2 * g))     lo_q[g] <= wr_data;
        if (wr_addr == 3'(2 * g + 1)) hi_q[g] <= wr_data;
      end
      if (wr_addr == A_TOL) tol_q    <= wr_data;
      if (wr_addr == A_CTL) ref_en_q <= wr_data[0];
    end
  end

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_cfg
      assign cfg[g].arm = hi_q[g][7];
      assign cfg[g].cnt = {hi_q[g][6:0], lo_q[g]};
      assign cfg[g].tol = tol_q[TOL_W*g +: TOL_W];
    end
  endgenerate

  assign ref_en = ref_en_q;

  AST_REF_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CTL) |=> (ref_en == $past(wr_data[0]))); // R2
endmodule

// File: rtl/fwc_sync.sv
`timescale 1ns/1ps
module fwc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/fwc_tst_cnt.sv
`timescale 1ns/1ps
module fwc_tst_cnt #(
  parameter int CNT_W = 15
) (
  input  logic             tst_clk,
  input  logic             rst,
  output logic [CNT_W-1:0] gray
);
  logic [CNT_W-1:0] bin_q, bin_nx, gray_q;

  assign bin_nx = bin_q + CNT_W'(1);

  always_ff @(posedge tst_clk) begin
    if (rst) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_q <= bin_nx ^ (bin_nx >> 1);
    end
  end

  assign gray = gray_q;

  AST_GRAY_STEP: assert property (@(posedge tst_clk) disable iff (rst)
    $countones(gray_q ^ $past(gray_q)) <= 1); // R9
endmodule

// File: rtl/fwc_window.sv
`timescale 1ns/1ps
module fwc_window #(
  parameter int CNT_W   = 15,
  parameter int WIN_LEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ref_lvl,
  input  logic [CNT_W-1:0] cnt_gray,
  output logic             eval,
  output logic [CNT_W-1:0] meas
);
  localparam int WC_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(WIN_LEN - 1);

  logic             ref_d_q, ref_edge;
  logic [CNT_W-1:0] bin_c, bin_q, start_q, meas_q;
  logic [WC_W-1:0]  win_q;
  logic             primed_q, eval_q;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) bin_c[i] = ^(cnt_gray >> i);
  end

  assign ref_edge = ref_lvl & ~ref_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_d_q <= 1'b0;
      bin_q   <= '0;
    end else begin
      ref_d_q <= ref_lvl;
      bin_q   <= bin_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      primed_q <= 1'b0;
      win_q    <= '0;
      start_q  <= '0;
      meas_q   <= '0;
      eval_q   <= 1'b0;
    end else begin
      eval_q <= 1'b0;
      if (ref_edge) begin
        if (!primed_q) begin
          primed_q <= 1'b1;
          start_q  <= bin_q;
          win_q    <= '0;
        end else if (win_q == WC_LAST) begin
          eval_q  <= 1'b1;
          meas_q  <= bin_q - start_q;
          start_q <= bin_q;
          win_q   <= '0;
        end else begin
          win_q <= win_q + WC_W'(1);
        end
      end
    end
  end

  assign eval = eval_q;
  assign meas = meas_q;

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    win_q <= WC_LAST); // R3
  AST_CLR_HALTS: assert property (@(posedge clk) disable iff (rst)
    clr |=> !eval_q); // R8
  AST_EVAL_NEEDS_PRIME: assert property (@(posedge clk) disable iff (rst)
    eval_q |-> primed_q); // R7
endmodule

// File: rtl/fwc_cmp.sv
`timescale 1ns/1ps
module fwc_cmp
  import fwc_pkg::*;
#(
  parameter int CNT_W     = 15,
  parameter int TOL_SHIFT = 0
) (
  input  logic [CNT_W-1:0] meas,
  input  grp_cfg_t         cfg,
  output logic             hit
);
  localparam int DW = ((CNT_W > EXP_W) ? CNT_W : EXP_W) + TOL_W + TOL_SHIFT + 1;

  logic [DW-1:0] m_x, e_x, diff, lim;

  always_comb begin
    m_x  = DW'(meas);
    e_x  = DW'(cfg.cnt);
    diff = (m_x >= e_x) ? (m_x - e_x) : (e_x - m_x);
    lim  = DW'(cfg.tol) << TOL_SHIFT;
    hit  = cfg.arm && (diff <= lim);
  end
endmodule

// File: rtl/fwc_status.sv
`timescale 1ns/1ps
module fwc_status
  import fwc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             eval,
  input  logic [NGRP-1:0]  hits,
  output logic [NGRP-1:0]  match,
  output logic [SEL_W-1:0] sel,
  output logic             ok
);
  logic [NGRP-1:0]  match_q;
  logic [SEL_W-1:0] sel_c, sel_q;
  logic             ok_q;

  always_comb begin
    sel_c = '0;
    for (int g = NGRP - 1; g >= 0; g--) begin
      if (hits[g]) sel_c = SEL_W'(g);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      match_q <= '0;
      sel_q   <= '0;
      ok_q    <= 1'b0;
    end else if (eval) begin
      match_q <= hits;
      sel_q   <= sel_c;
      ok_q    <= |hits;
    end
  end

  assign match = match_q;
  assign sel   = sel_q;
  assign ok    = ok_q;

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!eval && !clr) |=> ($stable(ok_q) && $stable(match_q) && $stable(sel_q))); // R6
  AST_CLEAR_ON_HOLD: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!ok_q && match_q == '0)); // R7
  AST_SEL_ONLY_G1: assert property (@(posedge clk) disable iff (rst)
    (sel_q != '0) |-> (match_q[sel_q] && !match_q[0])); // R5
endmodule

// File: rtl/freq_window_chk.sv
`timescale 1ns/1ps
module freq_window_chk
  import fwc_pkg::*;
#(
  parameter int CNT_W     = 15,
  parameter int WIN_LEN   = 32,
  parameter int TOL_SHIFT = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tst_clk,
  input  logic       ref_clk,
  input  logic       chk_rst,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [1:0] grp_match,
  output logic       grp_hit,
  output logic       freq_ok
);
  grp_cfg_t [NGRP-1:0] cfg;
  logic                ref_en, clr, ref_lvl, tst_rst, eval;
  logic [CNT_W-1:0]    gray_t, gray_s, meas;
  logic [NGRP-1:0]     hits, match;
  logic [SEL_W-1:0]    sel;

  fwc_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg), .ref_en(ref_en)
  );

  fwc_sync #(.W(1)) u_tst_rst (
    .clk(tst_clk), .rst(1'b0), .d(rst), .q(tst_rst)
  );

  fwc_tst_cnt #(.CNT_W(CNT_W)) u_tst_cnt (
    .tst_clk(tst_clk), .rst(tst_rst), .gray(gray_t)
  );

  fwc_sync #(.W(CNT_W)) u_gray_sync (
    .clk(clk), .rst(rst), .d(gray_t), .q(gray_s)
  );

  fwc_sync #(.W(1)) u_ref_sync (
    .clk(clk), .rst(rst), .d(ref_clk), .q(ref_lvl)
  );

  assign clr = chk_rst | ~ref_en;

  fwc_window #(.CNT_W(CNT_W), .WIN_LEN(WIN_LEN)) u_window (
    .clk(clk), .rst(rst), .clr(clr), .ref_lvl(ref_lvl),
    .cnt_gray(gray_s), .eval(eval), .meas(meas)
  );

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_cmp
      fwc_cmp #(.CNT_W(CNT_W), .TOL_SHIFT(TOL_SHIFT)) u_cmp (
        .meas(meas), .cfg(cfg[g]), .hit(hits[g])
      );
      AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (eval && !cfg[g].arm) |=> !match[g]); // R4
    end
  endgenerate

  fwc_status u_status (
    .clk(clk), .rst(rst), .clr(clr), .eval(eval), .hits(hits),
    .match(match), .sel(sel), .ok(freq_ok)
  );

  assign grp_match = match;
  assign grp_hit   = sel[0];

  AST_OK_FROM_MATCH: assert property (@(posedge clk) disable iff (rst)
    freq_ok == (|grp_match)); // R5
  AST_REF_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    !ref_en |=> !freq_ok); // R8
endmodule

// File: tb/freq_window_chk_bench.sv
`timescale 1ns/1ps
module freq_window_chk_bench;
  typedef struct packed {
    int unsigned half;
    logic [14:0] e0;
    logic        a0;
    logic [14:0] e1;
    logic        a1;
    logic [3:0]  t0;
    logic [3:0]  t1;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{5,  15'd128, 1'b1, 15'd0,   1'b0, 4'd0,  4'd0},
    '{5,  15'd130, 1'b1, 15'd125, 1'b1, 4'd2,  4'd2},
    '{5,  15'd131, 1'b1, 15'd126, 1'b1, 4'd2,  4'd2},
    '{4,  15'd128, 1'b1, 15'd160, 1'b1, 4'd15, 4'd15},
    '{8,  15'd80,  1'b1, 15'd80,  1'b1, 4'd0,  4'd0},
    '{10, 15'd64,  1'b0, 15'd64,  1'b0, 4'd15, 4'd15},
    '{5,  15'd143, 1'b1, 15'd144, 1'b1, 4'd15, 4'd15},
    '{20, 15'd32,  1'b1, 15'd200, 1'b1, 4'd0,  4'd15}
  };

  logic       clk = 1'b0, rst = 1'b1, tst_clk = 1'b0, ref_clk = 1'b0;
  logic       chk_rst = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] grp_match;
  logic       grp_hit, freq_ok;
  realtime    tst_half = 5.0;
  int         checks = 0, failures = 0;

  freq_window_chk u_freq_window_chk (
    .clk(clk), .rst(rst), .tst_clk(tst_clk), .ref_clk(ref_clk),
    .chk_rst(chk_rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .grp_match(grp_match), .grp_hit(grp_hit), .freq_ok(freq_ok)
  );

  initial forever #2 clk = ~clk;
  initial begin #0.3; forever #20 ref_clk = ~ref_clk; end
  initial begin #0.5; forever #(tst_half) tst_clk = ~tst_clk; end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk);
    chk_rst = 1'b1;
    cycles(3);
    chk_rst = 1'b0;
  endtask

  task automatic setup(input vec_t v);
    tst_half = realtime'(v.half);
    wr(3'd0, v.e0[7:0]);
    wr(3'd1, {v.a0, v.e0[14:8]});
    wr(3'd2, v.e1[7:0]);
    wr(3'd3, {v.a1, v.e1[14:8]});
    wr(3'd4, {v.t1, v.t0});
    wr(3'd5, 8'h01);
    restart();
    cycles(400);
  endtask

  function automatic int want(input vec_t v, input int g);
    int meas, e, d, t;
    logic a;
    meas = 1280 / (2 * int'(v.half));
    e = (g == 0) ? int'(v.e0) : int'(v.e1);
    a = (g == 0) ? v.a0 : v.a1;
    t = (g == 0) ? int'(v.t0) : int'(v.t1);
    d = (meas > e) ? meas - e : e - meas;
    return (a && d <= t) ? 1 : 0;
  endfunction

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vec_t v;
    cycles(5);
    rst = 1'b0;
    cycles(2);
    chk("R1 reset freq_ok", int'(freq_ok), 0);
    chk("R1 reset grp_match", int'(grp_match), 0);
    chk("R1 reset grp_hit", int'(grp_hit), 0);
    wr(3'd5, 8'h01);
    cycles(800);
    chk("R1 unarmed after reset", int'(freq_ok), 0);

    for (int i = 0; i < NV; i++) begin
      int m0, m1;
      setup(VECS[i]);
      m0 = want(VECS[i], 0);
      m1 = want(VECS[i], 1);
      chk($sformatf("R3 vec%0d grp_match0", i), int'(grp_match[0]), m0);
      chk($sformatf("R3 vec%0d grp_match1", i), int'(grp_match[1]), m1);
      chk($sformatf("R5 vec%0d freq_ok", i), int'(freq_ok), m0 | m1);
      chk($sformatf("R5 vec%0d grp_hit", i), int'(grp_hit), (m1 & ~m0));
    end

    // R4: count equal but arm bit clear
    v = '{5, 15'd128, 1'b0, 15'd128, 1'b0, 4'd15, 4'd15};
    setup(v);
    chk("R4 unarmed exact count", int'(freq_ok), 0);

    // R10: tolerance 0, one count off
    v = '{5, 15'd129, 1'b1, 15'd127, 1'b1, 4'd0, 4'd0};
    setup(v);
    chk("R10 zero tolerance off by one", int'(freq_ok), 0);

    // R9: fastest test clock, exact count 160
    v = '{4, 15'd160, 1'b1, 15'd0, 1'b0, 4'd0, 4'd0};
    setup(v);
    chk("R9 exact count at 125 MHz", int'(grp_match[0]), 1);

    // R2: high-byte field moves the expected count to 0x180
    v = '{5, 15'd128, 1'b1, 15'd0, 1'b0, 4'd0, 4'd0};
    setup(v);
    chk("R2 exp 0x080 matches", int'(freq_ok), 1);
    wr(3'd1, 8'h81);
    restart();
    cycles(400);
    chk("R2 exp 0x180 rejected", int'(freq_ok), 0);
    wr(3'd1, 8'h80);
    wr(3'd4, 8'hF0);
    restart();
    cycles(400);
    chk("R2 tolerance nibble of group1 unused by group0", int'(freq_ok), 1);

    // R6: mid-window config change holds status
    restart();
    cycles(375);
    chk("R6 match before change", int'(freq_ok), 1);
    wr(3'd0, 8'h90);
    cycles(25);
    chk("R6 held mid-window", int'(freq_ok), 1);
    cycles(350);
    chk("R6 updated next window", int'(freq_ok), 0);
    wr(3'd0, 8'h80);

    // R7: hold, release timing
    @(negedge clk);
    chk_rst = 1'b1;
    cycles(500);
    chk("R7 low while held", int'(freq_ok), 0);
    chk_rst = 1'b0;
    cycles(250);
    chk("R7 no early evaluation", int'(freq_ok), 0);
    cycles(150);
    chk("R7 first window result", int'(freq_ok), 1);

    // R8: reference disable
    wr(3'd5, 8'h00);
    cycles(2);
    chk("R8 low after disable", int'(freq_ok), 0);
    cycles(800);
    chk("R8 stays low disabled", int'(grp_match), 0);
    wr(3'd5, 8'h01);
    cycles(400);
    chk("R8 resumes after enable", int'(freq_ok), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule